// File: doc/BRIEF.md
# Vector Wide Add/Subtract Unit

This unit decodes and executes a family of SIMD integer instructions in which each wide lane of the result is formed from two operands of different widths. The first operand is a full wide element from the first source vector. The second operand is one half-width element taken from the same lane position of the second source vector, and it is widened before use. Three instruction bits choose between add and subtract, signed and unsigned widening, and the low or high narrow slot of the lane.

The surrounding pipeline presents a 32-bit instruction word and two source vectors together with a strobe. One cycle later the unit returns the result vector, the register indices carried in the instruction, a write-enable for a legal matching instruction and a flag for a matching word whose lane-size field has no valid form. The vector width is a parameter (128 bits by default). Lanes are numbered from the least-significant end of the vector.

Top module: `vwide_addsub_unit`

## Requirements
- R1: A word is accepted only when bits 31:24 equal 8'b01000101, bit 21 is 0 and bits 15:13 equal 3'b010; an accepted word with a nonzero size field raises `out_wen` one cycle after the strobe.
- R2: Bit 12 of the word picks subtract (1) or add (0); each result lane is first operand minus or plus the widened second operand.
- R3: Bit 11 picks unsigned (1) or signed (0) widening: the narrow element is zero-extended in the unsigned forms and sign-extended in the signed forms.
- R4: Bit 10 picks the narrow slot: 0 takes the low half of each wide lane of `src_b`, 1 takes the high half (offset of one narrow width within the lane).
- R5: Bits 23:22 set the lane size: 1 gives 16-bit lanes over 8-bit narrow elements, 2 gives 32/16, 3 gives 64/32; lane 0 sits in the least-significant bits.
- R6: An accepted word with size field 0 raises `out_illegal`, keeps `out_wen` low and forces `out_result` to zero.
- R7: Each result lane is truncated to the lane width with wraparound; no saturation occurs.
- R8: A word that is not accepted gives zero `out_result`, low `out_wen` and low `out_illegal`.
- R9: `out_rd`, `out_rn` and `out_rm` carry bits 4:0, 9:5 and 20:16 of the word presented with the strobe.
- R10: `out_valid` follows `in_valid` by exactly one cycle; with no strobe, `out_wen` and `out_illegal` stay low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input strobe |
| insn | input | 32 | Instruction word |
| src_a | input | VLEN | First source vector (wide elements) |
| src_b | input | VLEN | Second source vector (narrow elements) |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_wen | output | 1 | Legal matching instruction, write the result |
| out_illegal | output | 1 | Matching word with invalid lane size |
| out_rd | output | 5 | Destination register index |
| out_rn | output | 5 | First source register index |
| out_rm | output | 5 | Second source register index |
| out_result | output | VLEN | Result vector |

## Verification
Widening and wraparound meet in the same lane: a subtract of a sign-extended negative narrow element, or an unsigned add onto an all-ones wide element, both widen and overflow the lane in one operation, and the bench drives such operands in every lane and compares each lane against a reference computed from the requirements. The illegal-size flag and the register-index outputs also land in the same cycle; the bench issues a size-0 word with distinct index fields and checks that the indices still pass while the result is zero and the write-enable stays low. Back-to-back strobes with a rejected word following a legal one show that nothing of the first leaks into the second.

// File: rtl/vwas_pkg.sv
package vwas_pkg;

    localparam logic [7:0] VWAS_MAJOR = 8'b0100_0101;
    localparam logic [2:0] VWAS_MINOR = 3'b010;

    typedef enum logic [1:0] {
        SZ_NONE = 2'd0,
        SZ_H    = 2'd1,
        SZ_S    = 2'd2,
        SZ_D    = 2'd3
    } vwas_size_e;

    typedef struct packed {
        logic sub;
        logic uns;
        logic top;
    } vwas_op_t;

    typedef struct packed {
        logic       match;
        logic       illegal;
        vwas_size_e size;
        vwas_op_t   op;
        logic [4:0] rd;
        logic [4:0] rn;
        logic [4:0] rm;
    } vwas_dec_t;

    function automatic logic word_matches(input logic [31:0] w);
        return (w[31:24] == VWAS_MAJOR) && !w[21] && (w[15:13] == VWAS_MINOR);
    endfunction

endpackage

// File: rtl/vwas_decoder.sv
module vwas_decoder
    import vwas_pkg::*;
(
    input  logic [31:0] insn,
    output vwas_dec_t   dec
);
    always_comb begin
        dec.match   = word_matches(insn);
        dec.size    = vwas_size_e'(insn[23:22]);
        dec.illegal = dec.match && (dec.size == SZ_NONE);
        dec.op.sub  = insn[12];
        dec.op.uns  = insn[11];
        dec.op.top  = insn[10];
        dec.rd      = insn[4:0];
        dec.rn      = insn[9:5];
        dec.rm      = insn[20:16];
    end
endmodule

// File: rtl/vwas_lane_array.sv
module vwas_lane_array
    import vwas_pkg::*;
#(
    parameter int VLEN = 128,
    parameter int LW   = 16
) (
    input  logic [VLEN-1:0] src_a,
    input  logic [VLEN-1:0] src_b,
    input  vwas_op_t        op,
    output logic [VLEN-1:0] res
);
    localparam int NW = LW / 2;
    localparam int NL = VLEN / LW;

    for (genvar i = 0; i < NL; i++) begin : g_lane
        logic [LW-1:0] wide;
        logic [NW-1:0] narrow;
        logic [LW-1:0] ext;

        always_comb begin
            wide   = src_a[i*LW +: LW];
            narrow = op.top ? src_b[i*LW+NW +: NW] : src_b[i*LW +: NW];
            ext    = {{NW{~op.uns & narrow[NW-1]}}, narrow};
            res[i*LW +: LW] = op.sub ? (wide - ext) : (wide + ext);
        end
    end
endmodule

// File: rtl/vwide_addsub_unit.sv
module vwide_addsub_unit
    import vwas_pkg::*;
#(
    parameter int VLEN = 128
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [31:0]     insn,
    input  logic [VLEN-1:0] src_a,
    input  logic [VLEN-1:0] src_b,
    output logic            out_valid,
    output logic            out_wen,
    output logic            out_illegal,
    output logic [4:0]      out_rd,
    output logic [4:0]      out_rn,
    output logic [4:0]      out_rm,
    output logic [VLEN-1:0] out_result
);
    vwas_dec_t       dec;
    logic [VLEN-1:0] by_size [1:3];
    logic [VLEN-1:0] sel;
    logic            legal;

    vwas_decoder u_dec (.insn(insn), .dec(dec));

    for (genvar s = 1; s <= 3; s++) begin : g_size
        vwas_lane_array #(.VLEN(VLEN), .LW(8 << s)) u_lanes (
            .src_a(src_a),
            .src_b(src_b),
            .op   (dec.op),
            .res  (by_size[s])
        );
    end

    always_comb begin
        case (dec.size)
            SZ_H:    sel = by_size[1];
            SZ_S:    sel = by_size[2];
            SZ_D:    sel = by_size[3];
            default: sel = '0;
        endcase
        legal = in_valid && dec.match && !dec.illegal;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            out_wen     <= 1'b0;
            out_illegal <= 1'b0;
            out_rd      <= '0;
            out_rn      <= '0;
            out_rm      <= '0;
            out_result  <= '0;
        end else begin
            out_valid   <= in_valid;
            out_wen     <= legal;
            out_illegal <= in_valid && dec.illegal;
            out_rd      <= dec.rd;
            out_rn      <= dec.rn;
            out_rm      <= dec.rm;
            out_result  <= legal ? sel : '0;
        end
    end
endmodule

// File: rtl/vwas_checker.sv
module vwas_checker #(
    parameter int VLEN = 128
) (
    input logic            clk,
    input logic            rst,
    input logic            in_valid,
    input logic [31:0]     insn,
    input logic            out_valid,
    input logic            out_wen,
    input logic            out_illegal,
    input logic [4:0]      out_rd,
    input logic [4:0]      out_rn,
    input logic [4:0]      out_rm,
    input logic [VLEN-1:0] out_result
);
    logic accepted;
    assign accepted = (insn[31:24] == 8'b0100_0101) && !insn[21] && (insn[15:13] == 3'b010);

    p_strobe_follow_r10: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    p_idle_follow_r10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid && !out_wen && !out_illegal);
    p_size0_flag_r6: assert property (@(posedge clk) disable iff (rst)
        in_valid && accepted && insn[23:22] == 2'b00 |=> out_illegal && !out_wen);
    p_reject_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        in_valid && !accepted |=> !out_wen && !out_illegal && out_result == '0);
    p_accept_wen_r1: assert property (@(posedge clk) disable iff (rst)
        in_valid && accepted && insn[23:22] != 2'b00 |=> out_wen);
    p_zero_without_wen_r6: assert property (@(posedge clk) disable iff (rst)
        !out_wen |-> out_result == '0);
    p_index_pass_r9: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_rd == $past(insn[4:0]) && out_rn == $past(insn[9:5])
                     && out_rm == $past(insn[20:16]));
endmodule

bind vwide_addsub_unit vwas_checker #(.VLEN(VLEN)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .insn       (insn),
    .out_valid  (out_valid),
    .out_wen    (out_wen),
    .out_illegal(out_illegal),
    .out_rd     (out_rd),
    .out_rn     (out_rn),
    .out_rm     (out_rm),
    .out_result (out_result)
);

// File: tb/vwide_addsub_unit_tb.sv
`timescale 1ns/1ps
module vwide_addsub_unit_tb_top;
    localparam int VLEN = 128;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            in_valid = 1'b0;
    logic [31:0]     insn = '0;
    logic [VLEN-1:0] src_a = '0;
    logic [VLEN-1:0] src_b = '0;
    logic            out_valid, out_wen, out_illegal;
    logic [4:0]      out_rd, out_rn, out_rm;
    logic [VLEN-1:0] out_result;

    int n_checks = 0;
    int n_errors = 0;

    always #2 clk = ~clk;

    vwide_addsub_unit #(.VLEN(VLEN)) dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .insn(insn),
        .src_a(src_a), .src_b(src_b), .out_valid(out_valid),
        .out_wen(out_wen), .out_illegal(out_illegal), .out_rd(out_rd),
        .out_rn(out_rn), .out_rm(out_rm), .out_result(out_result)
    );

    function automatic logic [31:0] mk(input logic sub, input logic uns, input logic top,
                                       input logic [1:0] sz, input logic [4:0] rd,
                                       input logic [4:0] rn, input logic [4:0] rm);
        return {8'b0100_0101, sz, 1'b0, rm, 3'b010, sub, uns, top, rn, rd};
    endfunction

    function automatic logic [VLEN-1:0] expect_vec(input logic [31:0] w,
                                                   input logic [VLEN-1:0] a,
                                                   input logic [VLEN-1:0] b);
        logic [VLEN-1:0] acc = '0;
        int lw = 8 << w[23:22];
        int nw = lw / 2;
        logic [63:0] lmask = (lw == 64) ? {64{1'b1}} : ((64'd1 << lw) - 64'd1);
        logic [63:0] nmask = (64'd1 << nw) - 64'd1;
        for (int i = 0; i < VLEN / lw; i++) begin
            logic [63:0] av = 64'(a >> (i * lw)) & lmask;
            logic [63:0] nv = 64'(b >> (i * lw + (w[10] ? nw : 0))) & nmask;
            logic [63:0] rv;
            if (!w[11] && nv[nw-1]) nv = nv | ~nmask;
            rv = (w[12] ? av - nv : av + nv) & lmask;
            acc = acc | ({64'd0, rv} << (i * lw));
        end
        return acc;
    endfunction

    task automatic chk(input string req, input logic [VLEN-1:0] act, input logic [VLEN-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // drive one strobe, sample one cycle later away from the edge
    task automatic issue(input logic [31:0] w, input logic [VLEN-1:0] a, input logic [VLEN-1:0] b);
        @(negedge clk);
        insn = w; src_a = a; src_b = b; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R10 reset valid", VLEN'(out_valid), '0);
        chk("R10 reset wen/illegal", VLEN'({out_wen, out_illegal}), '0);
        chk("R10 reset result", out_result, '0);
    endtask

    task automatic t_all_ops();
        logic [VLEN-1:0] a = 128'h8000_7FFF_0123_4567_89AB_CDEF_FEDC_BA98;
        logic [VLEN-1:0] b = 128'h80FF_7F01_F00F_8877_1234_FF00_00FF_A55A;
        for (int sz = 1; sz <= 3; sz++) begin
            for (int op = 0; op < 8; op++) begin
                logic [31:0] w = mk(op[2], op[1], op[0], 2'(sz), 5'd3, 5'd4, 5'd5);
                issue(w, a, b);
                chk($sformatf("R2 R3 R4 R5 size%0d op%0d", sz, op), out_result, expect_vec(w, a, b));
                chk("R1 wen", VLEN'(out_wen), 1);
            end
        end
    endtask

    task automatic t_slot_select();
        // R4: low slots hold 1, high slots hold 2 in 16-bit lanes
        logic [VLEN-1:0] b = {8{8'h02, 8'h01}};
        issue(mk(0, 1, 0, 2'd1, 0, 0, 0), '0, b);
        chk("R4 bottom slot", out_result, {8{16'h0001}});
        issue(mk(0, 1, 1, 2'd1, 0, 0, 0), '0, b);
        chk("R4 top slot", out_result, {8{16'h0002}});
    endtask

    task automatic t_extension();
        logic [VLEN-1:0] b = {4{32'h0000_8000}};
        issue(mk(0, 0, 0, 2'd2, 0, 0, 0), '0, b);
        chk("R3 sign extend", out_result, {4{32'hFFFF_8000}});
        issue(mk(0, 1, 0, 2'd2, 0, 0, 0), '0, b);
        chk("R3 zero extend", out_result, {4{32'h0000_8000}});
    endtask

    task automatic t_lane_order();
        // R5: only lane 0 gets a nonzero narrow operand
        issue(mk(0, 1, 0, 2'd3, 0, 0, 0), '0, 128'd7);
        chk("R5 lane 0 at LSB", out_result, 128'd7);
    endtask

    task automatic t_wrap();
        issue(mk(0, 1, 0, 2'd1, 0, 0, 0), {8{16'hFFFF}}, {8{16'h0001}});
        chk("R7 unsigned add wrap", out_result, '0);
        issue(mk(1, 0, 0, 2'd3, 0, 0, 0), {2{64'h7FFF_FFFF_FFFF_FFFF}}, {2{64'h0000_0000_FFFF_FFFF}});
        chk("R7 signed sub wrap", out_result, {2{64'h8000_0000_0000_0000}});
        issue(mk(1, 1, 1, 2'd2, 0, 0, 0), '0, {4{32'h0001_0000}});
        chk("R7 unsigned sub wrap", out_result, {4{32'hFFFF_FFFF}});
    endtask

    task automatic t_illegal();
        issue(mk(0, 0, 0, 2'd0, 5'd17, 5'd9, 5'd30), {8{16'h1111}}, {8{16'h2222}});
        chk("R6 illegal flag", VLEN'(out_illegal), 1);
        chk("R6 no wen", VLEN'(out_wen), 0);
        chk("R6 zero result", out_result, '0);
        chk("R9 indices with illegal", VLEN'({out_rd, out_rn, out_rm}), VLEN'({5'd17, 5'd9, 5'd30}));
    endtask

    task automatic t_reject();
        logic [31:0] good = mk(0, 0, 0, 2'd1, 1, 2, 3);
        logic [31:0] bad [3];
        bad[0] = good | 32'h0020_0000;
        bad[1] = good ^ 32'h0000_4000;
        bad[2] = good ^ 32'h1000_0000;
        for (int k = 0; k < 3; k++) begin
            issue(bad[k], {8{16'h1234}}, {8{16'h0101}});
            chk($sformatf("R8 reject %0d result", k), out_result, '0);
            chk($sformatf("R8 reject %0d flags", k), VLEN'({out_wen, out_illegal}), '0);
        end
    endtask

    task automatic t_fields();
        issue(mk(0, 0, 0, 2'd1, 5'd31, 5'd1, 5'd16), '0, '0);
        chk("R9 rd", VLEN'(out_rd), 31);
        chk("R9 rn", VLEN'(out_rn), 1);
        chk("R9 rm", VLEN'(out_rm), 16);
    endtask

    task automatic t_back_to_back();
        logic [31:0] w1 = mk(0, 1, 0, 2'd1, 2, 0, 0);
        logic [VLEN-1:0] a = {8{16'h0100}};
        logic [VLEN-1:0] b = {8{16'h0005}};
        @(negedge clk);
        insn = w1; src_a = a; src_b = b; in_valid = 1'b1;
        @(negedge clk);
        chk("R10 first valid", VLEN'(out_valid), 1);
        chk("R1 first result", out_result, {8{16'h0105}});
        insn = w1 ^ 32'h0000_2000;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R8 second rejected", VLEN'({out_valid, out_wen}), VLEN'(2'b10));
        chk("R8 second result", out_result, '0);
        @(negedge clk);
        chk("R10 idle", VLEN'({out_valid, out_wen, out_illegal}), '0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        t_reset();
        t_all_ops();
        t_slot_select();
        t_extension();
        t_lane_order();
        t_wrap();
        t_illegal();
        t_reject();
        t_fields();
        t_back_to_back();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule